// File: doc/BRIEF.md
# Shared System Bus Arbiter

This block decides which of several masters owns a shared on-chip system bus. One configuration master, one host-bridge master and a parameterised number of user-logic masters each raise a request line. The arbiter returns a one-hot grant vector and the binary number of the owning master. Exactly one grant is asserted in every cycle after reset.

Arbitration has two tiers. A configuration request beats every other master. Among the host bridge and the user masters, a 2-bit priority setting chooses one of three schemes: host first, users first, or round-robin rotation. In round-robin the search starts at the master after the one that last won the second tier. The current owner keeps the bus while it requests and signals a burst in progress, so a burst is never split. A new decision is registered and takes effect one clock after the cycle in which it is made. When nobody requests, the grant parks on the host bridge.

Top module: `bus_arbiter`

## Requirements
- R1: In every cycle after reset exactly one bit of `grant` is set, and `owner` holds its index. Master indices are 0 for configuration, 1 for the host bridge and 2+i for user master i.
- R2: During and right after reset, `grant` selects the host bridge (index 1) and the round-robin pointer points at the host bridge.
- R3: When the owner is not holding the bus, a configuration request wins the next grant, whatever the other requests and the priority setting are.
- R4: With `prio_mode` = 2'b00 and no configuration request, the host bridge wins over the user masters. Among user masters the lowest index wins.
- R5: With `prio_mode` = 2'b01 and no configuration request, any requesting user master (lowest index first) wins over the host bridge.
- R6: With `prio_mode[1]` = 1 and no configuration request, the winner is the first requesting master found by searching the cyclic order host, user 0, ..., user N-1. The search starts just after the master that most recently won a second-tier arbitration, in any mode.
- R7: While `burst_active` is high and the current owner's request is high, `grant` and `owner` do not change, even if the configuration master requests.
- R8: A decision depends on the inputs seen at a rising clock edge. It appears on `grant` and `owner` after that edge, never earlier.
- R9: When the owner is not holding the bus and no master requests, the grant parks on the host bridge (index 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Request from the configuration master |
| host_req | input | 1 | Request from the host-bridge master |
| usr_req | input | N_USER | Requests from the user-logic masters, bit i is user i |
| burst_active | input | 1 | High while the current owner is in the middle of a burst |
| prio_mode | input | 2 | 00 host first, 01 users first, 1x round-robin |
| grant | output | N_USER+2 | One-hot grant; bit 0 configuration, bit 1 host, bit 2+i user i |
| owner | output | clog2(N_USER+2) | Binary index of the granted master |

## Verification
Each grant and owner result is due exactly one rising edge after the inputs that cause it. The bench applies inputs on the falling edge. It first checks that the outputs still show the previous decision, then steps its behavioural model at the rising edge and compares on the following falling edge. The model keeps its own owner and round-robin pointer as integers. Directed sequences cover parking, each priority mode, rotation and a burst held against a configuration request. Randomised traffic then mixes modes and burst lengths.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

   // Priority setting encodings for the second tier
   localparam logic [1:0] PRIO_HOST_FIRST = 2'b00;
   localparam logic [1:0] PRIO_USER_FIRST = 2'b01;

   // Fixed master indices
   localparam int IDX_CFG  = 0;
   localparam int IDX_HOST = 1;

   // Binary index of the lowest set bit of a one-hot word (0 if empty)
   function automatic int unsigned onehot_to_idx(input logic [31:0] vec);
      int unsigned res;
      res = 0;
      for (int i = 31; i >= 0; i--) begin
         if (vec[i]) res = i;
      end
      return res;
   endfunction

endpackage

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
   parameter int N_USER = 2,
   localparam int M2 = N_USER + 1
) (
   input  logic              host_req,
   input  logic [N_USER-1:0] usr_req,
   input  logic              user_first,
   output logic [M2-1:0]     pick
);

   logic [N_USER-1:0] usr_pick;
   logic              usr_any;

   // Lowest-index user wins among users
   always_comb begin
      logic seen;
      seen     = 1'b0;
      usr_pick = '0;
      for (int i = 0; i < N_USER; i++) begin
         usr_pick[i] = usr_req[i] & ~seen;
         seen        = seen | usr_req[i];
      end
      usr_any = seen;
   end

   always_comb begin
      pick[0] = host_req & (~user_first | ~usr_any);
      if (user_first || !host_req) pick[M2-1:1] = usr_pick;
      else                         pick[M2-1:1] = '0;
   end

   // R4/R5: the fixed picker never selects a non-requesting master
   always_comb begin
      assert_fixed_legal_R4: assert ((pick & ~{usr_req, host_req}) == '0)
         else $error("fixed picker chose an idle master");
   end

endmodule

// File: rtl/arb_rotate_pick.sv
module arb_rotate_pick #(
   parameter int N_USER = 2,
   localparam int M2 = N_USER + 1,
   localparam int LW = $clog2(M2)
) (
   input  logic [M2-1:0] req2,
   input  logic [LW-1:0] last_idx,
   output logic [M2-1:0] pick
);

   // Search begins one place after the last winner, wrapping around
   always_comb begin
      logic found;
      int   idx;
      found = 1'b0;
      pick  = '0;
      for (int k = 1; k <= M2; k++) begin
         idx = int'(last_idx) + k;
         if (idx >= M2) idx = idx - M2;
         if (!found && req2[idx]) begin
            pick[idx] = 1'b1;
            found     = 1'b1;
         end
      end
   end

   // R6: at most one pick, and only among requesters
   always_comb begin
      assert_rotate_onehot_R6: assert ($onehot0(pick) && ((pick & ~req2) == '0))
         else $error("rotating picker produced an illegal vector");
   end

endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg #(
   parameter int N_MST = 4,
   parameter int PARK  = 1,
   localparam int OWN_W = $clog2(N_MST)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_MST-1:0] grant_d,
   output logic [N_MST-1:0] grant_q,
   output logic [OWN_W-1:0] owner_q
);
   import bus_arb_pkg::*;

   localparam logic [N_MST-1:0] PARK_VEC = N_MST'(1) << PARK;

   logic [OWN_W-1:0] owner_d;

   always_comb owner_d = OWN_W'(onehot_to_idx(32'(grant_d)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= PARK_VEC;
         owner_q <= OWN_W'(PARK);
      end else begin
         grant_q <= grant_d;
         owner_q <= owner_d;
      end
   end

   // R1: registered grant is one-hot and the owner index points at it
   assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant_q) == 1)
      else $error("grant not one-hot");
   assert_owner_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
      grant_q[owner_q])
      else $error("owner index does not match grant");

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
   parameter int N_USER = 2,
   localparam int N_MST = N_USER + 2,
   localparam int OWN_W = $clog2(N_MST)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_req,
   input  logic              host_req,
   input  logic [N_USER-1:0] usr_req,
   input  logic              burst_active,
   input  logic [1:0]        prio_mode,
   output logic [N_MST-1:0]  grant,
   output logic [OWN_W-1:0]  owner
);
   import bus_arb_pkg::*;

   localparam int M2 = N_USER + 1;
   localparam int LW = $clog2(M2);
   localparam logic [N_MST-1:0] CFG_VEC  = N_MST'(1) << IDX_CFG;
   localparam logic [N_MST-1:0] HOST_VEC = N_MST'(1) << IDX_HOST;

   generate
      if (N_USER < 1 || N_USER > 29) begin : g_bad_users
         $error("bus_arbiter: N_USER must lie in 1..29");
      end
   endgenerate

   logic [M2-1:0]    req2;
   logic [N_MST-1:0] req_all;
   logic [N_MST-1:0] grant_q;
   logic [N_MST-1:0] grant_d;
   logic [M2-1:0]    fix_pick;
   logic [M2-1:0]    rot_pick;
   logic [M2-1:0]    t2_pick;
   logic [LW-1:0]    rr_last;
   logic             hold;
   logic             t2_any;
   logic             t2_win;
   logic             use_rot;

   assign req2    = {usr_req, host_req};
   assign req_all = {req2, cfg_req};
   assign use_rot = prio_mode[1];
   assign t2_any  = |req2;

   // Owner keeps the bus while its burst runs
   assign hold = burst_active && ((req_all & grant_q) != '0);

   arb_fixed_pick #(.N_USER(N_USER)) u_fixed (
      .host_req   (host_req),
      .usr_req    (usr_req),
      .user_first (prio_mode == PRIO_USER_FIRST),
      .pick       (fix_pick)
   );

   arb_rotate_pick #(.N_USER(N_USER)) u_rotate (
      .req2     (req2),
      .last_idx (rr_last),
      .pick     (rot_pick)
   );

   assign t2_pick = use_rot ? rot_pick : fix_pick;
   assign t2_win  = !hold && !cfg_req && t2_any;

   always_comb begin
      if (hold)         grant_d = grant_q;
      else if (cfg_req) grant_d = CFG_VEC;
      else if (t2_any)  grant_d = {t2_pick, 1'b0};
      else              grant_d = HOST_VEC;
   end

   // Rotation pointer follows every second-tier winner
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rr_last <= '0;
      else if (t2_win) rr_last <= LW'(onehot_to_idx(32'(t2_pick)));
   end

   arb_grant_reg #(.N_MST(N_MST), .PARK(IDX_HOST)) u_greg (
      .clk     (clk),
      .rst_n   (rst_n),
      .grant_d (grant_d),
      .grant_q (grant_q),
      .owner_q (owner)
   );

   assign grant = grant_q;

   // R7: a running burst keeps its owner
   assert_burst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_active && (req_all & grant_q) != '0) |=> $stable(grant_q))
      else $error("grant moved during a burst");
   // R3: configuration wins at a boundary
   assert_cfg_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && cfg_req) |=> grant_q[IDX_CFG])
      else $error("configuration request lost");
   // R9: park on host when idle
   assert_park_host_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && req_all == '0) |=> grant_q[IDX_HOST])
      else $error("idle grant not parked on host");
   // R4: host-first mode favours a requesting host
   assert_host_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !cfg_req && host_req && prio_mode == PRIO_HOST_FIRST) |=> grant_q[IDX_HOST])
      else $error("host-first order violated");

endmodule

// File: tb/bus_arbiter_bench.sv
module bus_arbiter_bench;
   localparam int NU = 2;
   localparam int NM = NU + 2;
   localparam int OW = $clog2(NM);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_req = 1'b0;
   logic          host_req = 1'b0;
   logic [NU-1:0] usr_req = '0;
   logic          burst_active = 1'b0;
   logic [1:0]    prio_mode = 2'b00;
   logic [NM-1:0] grant;
   logic [OW-1:0] owner;

   int n_chk = 0;
   int n_bad = 0;
   int exp_owner = 1;
   int rr_last = 0;     // local second-tier index: 0 host, 1+i user i
   string tag = "R2";
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   bus_arbiter #(.N_USER(NU)) u_bus_arbiter (
      .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .host_req(host_req),
      .usr_req(usr_req), .burst_active(burst_active), .prio_mode(prio_mode),
      .grant(grant), .owner(owner)
   );

   function automatic bit req_of(int m);
      if (m == 0) return cfg_req;
      if (m == 1) return host_req;
      return usr_req[m-2];
   endfunction

   // Behavioural model step at a rising edge
   task automatic model_step();
      bit any2;
      int win;
      any2 = host_req || (usr_req != '0);
      if (burst_active && req_of(exp_owner)) begin
         tag = "R7";
      end else if (cfg_req) begin
         exp_owner = 0; tag = "R3";
      end else if (!any2) begin
         exp_owner = 1; tag = "R9";
      end else begin
         win = -1;
         if (prio_mode[1]) begin
            for (int k = 1; k <= NU + 1; k++) begin
               int j = (rr_last + k) % (NU + 1);
               if (win < 0 && req_of(j + 1)) win = j + 1;
            end
            tag = "R6";
         end else if (prio_mode == 2'b00) begin
            if (host_req) win = 1;
            else for (int i = NU - 1; i >= 0; i--) if (usr_req[i]) win = i + 2;
            tag = "R4";
         end else begin
            for (int i = NU - 1; i >= 0; i--) if (usr_req[i]) win = i + 2;
            if (win < 0) win = 1;
            tag = "R5";
         end
         exp_owner = win;
         rr_last = win - 1;
      end
   endtask

   task automatic compare(string t);
      logic [NM-1:0] eg;
      eg = NM'(1) << exp_owner;
      n_chk++;
      if (grant !== eg || owner !== OW'(exp_owner)) begin
         n_bad++;
         $display("FAIL %s/R1 grant=%b owner=%0d expected grant=%b owner=%0d",
                  t, grant, owner, eg, exp_owner);
      end
   endtask

   // Apply one vector at a falling edge, verify latency, step, compare
   task automatic cyc(input bit c, input bit h, input logic [NU-1:0] u,
                      input bit b, input logic [1:0] m);
      cfg_req = c; host_req = h; usr_req = u; burst_active = b; prio_mode = m;
      #1;
      compare("R8");            // nothing may change before the edge
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      @(negedge clk);
      compare("R2");
      @(negedge clk);
      rst_n = 1'b1;
      compare("R2");
      // idle parking
      cyc(0, 0, 2'b00, 0, 2'b00);
      // host-first ordering
      cyc(0, 1, 2'b01, 0, 2'b00);
      cyc(0, 0, 2'b11, 0, 2'b00);
      cyc(0, 0, 2'b10, 0, 2'b00);
      // user-first ordering
      cyc(0, 1, 2'b10, 0, 2'b01);
      cyc(0, 1, 2'b11, 0, 2'b01);
      cyc(0, 1, 2'b00, 0, 2'b01);
      // configuration override
      cyc(1, 1, 2'b11, 0, 2'b01);
      cyc(0, 0, 2'b00, 0, 2'b00);
      // burst held against configuration
      cyc(0, 0, 2'b10, 0, 2'b00);
      cyc(1, 0, 2'b10, 1, 2'b00);
      cyc(1, 1, 2'b10, 1, 2'b00);
      cyc(1, 1, 2'b10, 0, 2'b00);
      // rotation with everyone requesting
      for (int i = 0; i < 7; i++) cyc(0, 1, 2'b11, 0, 2'b10);
      cyc(0, 0, 2'b01, 0, 2'b11);
      cyc(0, 1, 2'b10, 0, 2'b11);
      // random traffic
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom;
         cyc((r % 9) == 0, r[4], r[6:5], (r[9:7] != 0), r[11:10]);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R1 run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule